// File: doc/BRIEF.md
# Burst Bus Controller with Locked Ownership and Debug Side Port

The controller links a small set of bus masters to a small set of memory-mapped slaves over a single non-pipelined data path. A master raises its request with a start word address, a beat count, a direction and a lock flag. It then watches its two-bit status output. An internal arbiter picks one master. The start address is compared against the inclusive address window of each slave, and the transfer then moves one word per clock on the shared slave port, with the address rising by one on each beat. Masters never stall, so the granted master has to present write data, or take read data, on every beat it is told about.

When a burst ends, the result (ok or error) shows on the owner's status for exactly one cycle. After that the bus goes back to arbitration. A master whose finished burst carried the lock flag wins the next arbitration if it is still requesting, ahead of any master of higher priority. Otherwise the lowest-numbered requesting master wins. If the start address hits no slave window, the burst ends in error with no beats. If a burst runs past the end of its window, it stops at the window's last word and ends in error.

A separate debug port reaches the slaves through the same address windows, on its own slave-side port. It has no arbitration and no clock delay: the decode, the select and the read data are all combinational. It therefore never disturbs a burst in flight.

Top module: `burst_bus_ctrl`

## Requirements
- R1: After reset every master status reads idle (2'b00), no slave select and no beat strobe are active, and the debug error flag is low while no debug request is present.
- R2: Status codes per master are 2'b00 idle (no request), 2'b01 busy (request raised and not yet finished), 2'b10 ok and 2'b11 error.
- R3: Slave s is selected when lo[s] <= address <= hi[s] (inclusive bounds, lowest-numbered slave on overlap), and s_sel is one-hot with bit s set during each beat to that slave.
- R4: A granted burst gives its first beat in the cycle after the arbitration edge and then one beat per cycle at addresses start, start+1, and so on. A burst carries as many beats as its length field, and a length of 0 gives one beat.
- R5: A start address outside every slave window ends the burst with error status and no beats.
- R6: A burst that would pass the last address of its slave window performs the in-window beats and then ends with error status.
- R7: With no lock in force, the lowest-numbered requesting master is granted.
- R8: A master whose last completed burst had the lock flag set is granted at the next arbitration if it is requesting, over a master of higher priority.
- R9: During a read beat, m_rdata carries the word the selected slave returns on s_rdata for the current address.
- R10: During a write beat, s_wr is high and s_wdata carries the owning master's m_wdata.
- R11: A debug request is decoded and serviced in the same cycle: ds_sel marks the hit slave, d_rdata returns that slave's word, and on a miss d_err is high with no slave selected. A debug access during a burst leaves the burst's beats unchanged.
- R12: The ok or error status lasts one cycle. The bus then arbitrates again, so a waiting master's first beat falls two cycles after the previous burst's result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req | input | NM | Per-master request |
| m_wr | input | NM | Per-master direction, 1 = write |
| m_lock | input | NM | Per-master lock flag |
| m_addr | input | NM*AW | Per-master start word address |
| m_len | input | NM*LW | Per-master beat count (0 counts as 1) |
| m_wdata | input | NM*DW | Per-master write word for the current beat |
| m_status | output | NM*2 | Per-master status code |
| m_beat | output | NM | Beat strobe for the owning master |
| m_rdata | output | DW | Read word during a read beat |
| slv_lo | input | NS*AW | First address of each slave window |
| slv_hi | input | NS*AW | Last address of each slave window |
| s_sel | output | NS | Burst-side slave select |
| s_wr | output | 1 | Burst-side write enable |
| s_addr | output | AW | Burst-side word address |
| s_wdata | output | DW | Burst-side write word |
| s_rdata | input | NS*DW | Burst-side read word from each slave |
| d_req | input | 1 | Debug access request |
| d_wr | input | 1 | Debug direction, 1 = write |
| d_addr | input | AW | Debug word address |
| d_wdata | input | DW | Debug write word |
| d_rdata | output | DW | Debug read word, same cycle |
| d_err | output | 1 | Debug address matched no slave |
| ds_sel | output | NS | Debug-side slave select |
| ds_wr | output | 1 | Debug-side write enable |
| ds_addr | output | AW | Debug-side word address |
| ds_wdata | output | DW | Debug-side write word |
| ds_rdata | input | NS*DW | Debug-side read word from each slave |

## Verification
The request is sampled at one clock edge. The first beat is visible in the half cycle after that edge. Each later beat follows one edge apart, and the ok or error status appears one edge after the last beat, or one edge after arbitration when the start address misses every window. The bench drives on falling edges and samples the beat, address and data outputs in the same half cycle. It drops the request in the status cycle and expects a waiting master's first beat exactly two falling edges later. Debug results are combinational, so they are checked a short delay after the debug inputs change, while a burst beat is in progress.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

    typedef enum logic [1:0] {
        STAT_IDLE = 2'b00,
        STAT_BUSY = 2'b01,
        STAT_OK   = 2'b10,
        STAT_ERR  = 2'b11
    } bbc_stat_e;

    typedef enum logic [1:0] {
        PH_ARB  = 2'b00,
        PH_XFER = 2'b01,
        PH_DONE = 2'b10
    } bbc_phase_e;

endpackage

// File: rtl/bbc_word_mux.sv
module bbc_word_mux #(
    parameter int N  = 2,
    parameter int W  = 8,
    parameter int IW = 1
) (
    input  logic [N*W-1:0] flat_i,
    input  logic [IW-1:0]  idx_i,
    output logic [W-1:0]   word_o
);

    always_comb begin
        word_o = '0;
        for (int k = 0; k < N; k++) begin
            if (idx_i == IW'(k)) begin
                word_o = flat_i[k*W +: W];
            end
        end
    end

endmodule

// File: rtl/bbc_range_dec.sv
module bbc_range_dec #(
    parameter int NS  = 2,
    parameter int AW  = 16,
    parameter int SIW = 1
) (
    input  logic [AW-1:0]    addr_i,
    input  logic [NS*AW-1:0] lo_i,
    input  logic [NS*AW-1:0] hi_i,
    output logic             hit_o,
    output logic [SIW-1:0]   idx_o
);

    logic [NS-1:0] match;

    // One inclusive window compare per slave
    for (genvar s = 0; s < NS; s++) begin : g_cmp
        assign match[s] = (addr_i >= lo_i[s*AW +: AW]) &&
                          (addr_i <= hi_i[s*AW +: AW]);
    end

    // Lowest-numbered matching slave wins on overlap
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (match[s]) begin
                hit_o = 1'b1;
                idx_o = SIW'(s);
            end
        end
    end

endmodule

// File: rtl/bbc_arbiter.sv
module bbc_arbiter #(
    parameter int NM  = 2,
    parameter int MIW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NM-1:0]  req_i,
    input  logic           lock_valid_i,
    input  logic [MIW-1:0] lock_id_i,
    output logic           any_o,
    output logic [MIW-1:0] gnt_id_o
);

    logic lock_hit;

    assign lock_hit = lock_valid_i && req_i[lock_id_i];

    always_comb begin
        any_o    = |req_i;
        gnt_id_o = '0;
        if (lock_hit) begin
            gnt_id_o = lock_id_i;
        end else begin
            for (int k = NM - 1; k >= 0; k--) begin
                if (req_i[k]) begin
                    gnt_id_o = MIW'(k);
                end
            end
        end
    end

    // R7: the grant always goes to a requesting master
    p_grant_requested_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[gnt_id_o]);

    // R7: without a lock in force, no lower-numbered master is left waiting
    p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_o && !lock_hit) |->
            ((req_i & ((NM'(1) << gnt_id_o) - NM'(1))) == '0));

endmodule

// File: rtl/burst_bus_ctrl.sv
module burst_bus_ctrl #(
    parameter int NM = 3,
    parameter int NS = 3,
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM-1:0]    m_req,
    input  logic [NM-1:0]    m_wr,
    input  logic [NM-1:0]    m_lock,
    input  logic [NM*AW-1:0] m_addr,
    input  logic [NM*LW-1:0] m_len,
    input  logic [NM*DW-1:0] m_wdata,
    output logic [NM*2-1:0]  m_status,
    output logic [NM-1:0]    m_beat,
    output logic [DW-1:0]    m_rdata,
    input  logic [NS*AW-1:0] slv_lo,
    input  logic [NS*AW-1:0] slv_hi,
    output logic [NS-1:0]    s_sel,
    output logic             s_wr,
    output logic [AW-1:0]    s_addr,
    output logic [DW-1:0]    s_wdata,
    input  logic [NS*DW-1:0] s_rdata,
    input  logic             d_req,
    input  logic             d_wr,
    input  logic [AW-1:0]    d_addr,
    input  logic [DW-1:0]    d_wdata,
    output logic [DW-1:0]    d_rdata,
    output logic             d_err,
    output logic [NS-1:0]    ds_sel,
    output logic             ds_wr,
    output logic [AW-1:0]    ds_addr,
    output logic [DW-1:0]    ds_wdata,
    input  logic [NS*DW-1:0] ds_rdata
);

    import bbc_pkg::*;

    localparam int MIW = (NM > 1) ? $clog2(NM) : 1;
    localparam int SIW = (NS > 1) ? $clog2(NS) : 1;

    typedef struct packed {
        bbc_phase_e     phase;
        logic [MIW-1:0] owner;
        logic [AW-1:0]  addr;
        logic [LW-1:0]  rem;
        logic [SIW-1:0] slv;
        logic           wr;
        logic           lock;
        logic           err;
        logic           lock_valid;
        logic [MIW-1:0] lock_id;
    } ctl_s;

    ctl_s r_d, r_q;

    logic           arb_any;
    logic [MIW-1:0] arb_id;
    logic [AW-1:0]  req_addr;
    logic [LW-1:0]  req_len;
    logic           start_hit;
    logic [SIW-1:0] start_idx;
    logic [AW-1:0]  cur_hi;
    logic [DW-1:0]  own_wdata;
    logic [DW-1:0]  slv_word;
    logic           dbg_hit;
    logic [SIW-1:0] dbg_idx;
    logic [DW-1:0]  dbg_word;
    logic           in_xfer;

    // Arbitration between masters
    bbc_arbiter #(.NM(NM), .MIW(MIW)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (m_req),
        .lock_valid_i (r_q.lock_valid),
        .lock_id_i    (r_q.lock_id),
        .any_o        (arb_any),
        .gnt_id_o     (arb_id)
    );

    // Fields of the winning request
    bbc_word_mux #(.N(NM), .W(AW), .IW(MIW)) u_mx_addr (
        .flat_i (m_addr), .idx_i (arb_id), .word_o (req_addr));
    bbc_word_mux #(.N(NM), .W(LW), .IW(MIW)) u_mx_len (
        .flat_i (m_len), .idx_i (arb_id), .word_o (req_len));

    // Owner's write word and current slave's last address
    bbc_word_mux #(.N(NM), .W(DW), .IW(MIW)) u_mx_wdata (
        .flat_i (m_wdata), .idx_i (r_q.owner), .word_o (own_wdata));
    bbc_word_mux #(.N(NS), .W(AW), .IW(SIW)) u_mx_hi (
        .flat_i (slv_hi), .idx_i (r_q.slv), .word_o (cur_hi));
    bbc_word_mux #(.N(NS), .W(DW), .IW(SIW)) u_mx_rd (
        .flat_i (s_rdata), .idx_i (r_q.slv), .word_o (slv_word));

    // Decode of the burst start address
    bbc_range_dec #(.NS(NS), .AW(AW), .SIW(SIW)) u_dec_bus (
        .addr_i (req_addr), .lo_i (slv_lo), .hi_i (slv_hi),
        .hit_o  (start_hit), .idx_o (start_idx));

    // Decode of the debug address
    bbc_range_dec #(.NS(NS), .AW(AW), .SIW(SIW)) u_dec_dbg (
        .addr_i (d_addr), .lo_i (slv_lo), .hi_i (slv_hi),
        .hit_o  (dbg_hit), .idx_o (dbg_idx));
    bbc_word_mux #(.N(NS), .W(DW), .IW(SIW)) u_mx_dbg (
        .flat_i (ds_rdata), .idx_i (dbg_idx), .word_o (dbg_word));

    // Next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_ARB: begin
                if (arb_any) begin
                    r_d.owner      = arb_id;
                    r_d.addr       = req_addr;
                    r_d.rem        = (req_len == '0) ? LW'(1) : req_len;
                    r_d.wr         = m_wr[arb_id];
                    r_d.lock       = m_lock[arb_id];
                    r_d.lock_valid = 1'b0;
                    r_d.slv        = start_idx;
                    if (start_hit) begin
                        r_d.phase = PH_XFER;
                        r_d.err   = 1'b0;
                    end else begin
                        r_d.phase = PH_DONE;
                        r_d.err   = 1'b1;
                    end
                end
            end
            PH_XFER: begin
                r_d.addr = r_q.addr + AW'(1);
                r_d.rem  = r_q.rem - LW'(1);
                if (r_q.rem == LW'(1)) begin
                    r_d.phase = PH_DONE;
                    r_d.err   = 1'b0;
                end else if (r_q.addr == cur_hi) begin
                    r_d.phase = PH_DONE;
                    r_d.err   = 1'b1;
                end
            end
            PH_DONE: begin
                r_d.phase      = PH_ARB;
                r_d.lock_valid = r_q.lock;
                r_d.lock_id    = r_q.owner;
            end
            default: r_d.phase = PH_ARB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Burst-side outputs
    assign in_xfer = (r_q.phase == PH_XFER);

    always_comb begin
        s_sel   = in_xfer ? (NS'(1) << r_q.slv) : '0;
        s_wr    = in_xfer && r_q.wr;
        s_addr  = r_q.addr;
        s_wdata = own_wdata;
        m_rdata = (in_xfer && !r_q.wr) ? slv_word : '0;
        for (int i = 0; i < NM; i++) begin
            m_beat[i] = in_xfer && (r_q.owner == MIW'(i));
            if (r_q.phase == PH_DONE && r_q.owner == MIW'(i)) begin
                m_status[2*i +: 2] = r_q.err ? STAT_ERR : STAT_OK;
            end else if (m_req[i]) begin
                m_status[2*i +: 2] = STAT_BUSY;
            end else begin
                m_status[2*i +: 2] = STAT_IDLE;
            end
        end
    end

    // Debug-side outputs, purely combinational
    always_comb begin
        ds_sel   = (d_req && dbg_hit) ? (NS'(1) << dbg_idx) : '0;
        ds_wr    = d_req && d_wr && dbg_hit;
        ds_addr  = d_addr;
        ds_wdata = d_wdata;
        d_rdata  = (d_req && dbg_hit && !d_wr) ? dbg_word : '0;
        d_err    = d_req && !dbg_hit;
    end

    // R3: at most one slave selected on the burst side
    p_one_slave_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_sel));

    // R4: at most one master sees a beat
    p_one_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_beat));

    // R4: back-to-back beats step the address by one
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|s_sel) && $past(|s_sel)) |-> (s_addr == AW'($past(s_addr) + AW'(1))));

    // R12: the result phase lasts a single cycle
    p_done_short_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_DONE) |=> (r_q.phase == PH_ARB));

    // R11: a debug miss touches no slave
    p_dbg_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_err) |-> ((ds_sel == '0) && !ds_wr));

endmodule

// File: tb/test_burst_bus_ctrl.sv
module test_burst_bus_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 3;
    localparam int NS = 3;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 8;

    localparam logic [1:0] ST_IDLE = 2'b00;
    localparam logic [1:0] ST_BUSY = 2'b01;
    localparam logic [1:0] ST_OK   = 2'b10;
    localparam logic [1:0] ST_ERR  = 2'b11;

    // master(2) wr(1) addr(16) len(8) beats(8) status(2)
    localparam int NVEC = 8;
    localparam logic [36:0] VEC [0:NVEC-1] = '{
        {2'd0, 1'b1, 16'h0010, 8'd4, 8'd4, 2'b10},  // R4 R10 write in window
        {2'd1, 1'b0, 16'h0010, 8'd4, 8'd4, 2'b10},  // R9 read back
        {2'd2, 1'b1, 16'h0020, 8'd8, 8'd8, 2'b10},  // R3 whole window
        {2'd0, 1'b0, 16'h0024, 8'd6, 8'd4, 2'b11},  // R6 crosses end
        {2'd1, 1'b0, 16'h0030, 8'd2, 8'd0, 2'b11},  // R5 unmapped
        {2'd2, 1'b1, 16'h004F, 8'd1, 8'd1, 2'b10},  // R3 last word
        {2'd0, 1'b0, 16'h0040, 8'd0, 8'd1, 2'b10},  // R4 length zero
        {2'd1, 1'b1, 16'h001E, 8'd3, 8'd2, 2'b11}   // R6 write crosses
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0]    m_req = '0, m_wr = '0, m_lock = '0;
    logic [NM*AW-1:0] m_addr = '0;
    logic [NM*LW-1:0] m_len = '0;
    wire  [NM*DW-1:0] m_wdata;
    wire  [NM*2-1:0]  m_status;
    wire  [NM-1:0]    m_beat;
    wire  [DW-1:0]    m_rdata;
    logic [NS*AW-1:0] slv_lo, slv_hi;
    wire  [NS-1:0]    s_sel;
    wire              s_wr;
    wire  [AW-1:0]    s_addr;
    wire  [DW-1:0]    s_wdata;
    wire  [NS*DW-1:0] s_rdata;
    logic             d_req = 1'b0, d_wr = 1'b0;
    logic [AW-1:0]    d_addr = '0;
    logic [DW-1:0]    d_wdata = '0;
    wire  [DW-1:0]    d_rdata;
    wire              d_err;
    wire  [NS-1:0]    ds_sel;
    wire              ds_wr;
    wire  [AW-1:0]    ds_addr;
    wire  [DW-1:0]    ds_wdata;
    wire  [NS*DW-1:0] ds_rdata;

    logic [DW-1:0] mem [0:255];
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slave windows: 0x10-0x1F, 0x20-0x27, 0x40-0x4F
    assign slv_lo = {16'h0040, 16'h0020, 16'h0010};
    assign slv_hi = {16'h004F, 16'h0027, 16'h001F};

    function automatic logic [DW-1:0] tag(input int s);
        return DW'(s + 1) << 28;
    endfunction

    function automatic int slave_of(input logic [AW-1:0] a);
        if (a >= 16'h0010 && a <= 16'h001F) return 0;
        if (a >= 16'h0020 && a <= 16'h0027) return 1;
        if (a >= 16'h0040 && a <= 16'h004F) return 2;
        return 3;
    endfunction

    function automatic logic [DW-1:0] pattern(input int mi, input logic [AW-1:0] a);
        return {8'(mi + 1), 8'h00, a};
    endfunction

    for (genvar g = 0; g < NM; g++) begin : g_mst
        assign m_wdata[g*DW +: DW] = pattern(g, s_addr);
    end
    for (genvar g = 0; g < NS; g++) begin : g_slv
        assign s_rdata[g*DW +: DW]  = mem[s_addr[7:0]] ^ tag(g);
        assign ds_rdata[g*DW +: DW] = mem[ds_addr[7:0]] ^ tag(g);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem[a] <= 32'h00A5_0000 + 32'(a * 3);
        end else begin
            if ((|s_sel) && s_wr) mem[s_addr[7:0]] <= s_wdata;
            if ((|ds_sel) && ds_wr) mem[ds_addr[7:0]] <= ds_wdata;
        end
    end

    burst_bus_ctrl #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .LW(LW)) i_burst_bus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_wr(m_wr), .m_lock(m_lock), .m_addr(m_addr),
        .m_len(m_len), .m_wdata(m_wdata), .m_status(m_status),
        .m_beat(m_beat), .m_rdata(m_rdata),
        .slv_lo(slv_lo), .slv_hi(slv_hi),
        .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_rdata(s_rdata),
        .d_req(d_req), .d_wr(d_wr), .d_addr(d_addr), .d_wdata(d_wdata),
        .d_rdata(d_rdata), .d_err(d_err),
        .ds_sel(ds_sel), .ds_wr(ds_wr), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic set_req(input int mi, input bit wr, input bit lk,
                           input logic [AW-1:0] a, input logic [LW-1:0] n);
        m_req[mi]            = 1'b1;
        m_wr[mi]             = wr;
        m_lock[mi]           = lk;
        m_addr[mi*AW +: AW]  = a;
        m_len[mi*LW +: LW]   = n;
    endtask

    function automatic logic [1:0] stat(input int mi);
        return m_status[2*mi +: 2];
    endfunction

    // Walk one table row: raise request, follow beats, collect result
    task automatic run_vec(input logic [36:0] v);
        int mi, beats;
        bit wr, done;
        logic [AW-1:0] a0;
        logic [1:0] st;
        mi = int'(v[36:35]); wr = v[34]; a0 = v[33:18];
        beats = 0; done = 0; st = ST_IDLE;
        @(negedge clk);
        set_req(mi, wr, 1'b0, a0, v[17:10]);
        for (int c = 0; c < 64 && !done; c++) begin
            @(negedge clk);
            if (m_beat[mi]) begin
                chk("R4 beat address", 64'(s_addr), 64'(a0 + AW'(beats)));
                chk("R3 slave select", 64'(s_sel), 64'(1 << slave_of(a0 + AW'(beats))));
                if (wr) begin
                    chk("R10 write data", {31'd0, s_wr, s_wdata},
                        {31'd0, 1'b1, pattern(mi, a0 + AW'(beats))});
                end else begin
                    chk("R9 read data", 64'(m_rdata),
                        64'(mem[8'(a0 + AW'(beats))] ^ tag(slave_of(a0 + AW'(beats)))));
                end
                beats++;
                chk("R2 busy during beat", 64'(stat(mi)), 64'(ST_BUSY));
            end
            st = stat(mi);
            if (st == ST_OK || st == ST_ERR) done = 1;
        end
        chk("R4 R5 R6 beat count", 64'(beats), 64'(v[9:2]));
        chk("R2 R5 R6 final status", 64'(st), 64'(v[1:0]));
        m_req[mi] = 1'b0;
    endtask

    task automatic wait_stat(input int mi);
        for (int c = 0; c < 64; c++) begin
            if (stat(mi) == ST_OK || stat(mi) == ST_ERR) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_beat();
        for (int c = 0; c < 64; c++) begin
            if (|m_beat) break;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 status idle", 64'(m_status), 64'(0));
        chk("R1 no select", 64'(s_sel), 64'(0));
        chk("R1 no beat", 64'(m_beat), 64'(0));
        chk("R1 no debug error", 64'(d_err), 64'(0));

        // Vector table
        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        // R7 and R12: simultaneous requests, lowest index first
        @(negedge clk);
        set_req(1, 1'b0, 1'b0, 16'h0020, 8'd1);
        set_req(2, 1'b0, 1'b0, 16'h0021, 8'd1);
        @(negedge clk);
        chk("R7 lower index first", 64'(m_beat), 64'(3'b010));
        chk("R2 waiting master busy", 64'(stat(2)), 64'(ST_BUSY));
        wait_stat(1);
        chk("R2 ok status", 64'(stat(1)), 64'(ST_OK));
        m_req[1] = 1'b0;
        @(negedge clk);
        chk("R12 no beat in arbitration cycle", 64'(m_beat), 64'(0));
        @(negedge clk);
        chk("R12 next grant two cycles after result", 64'(m_beat), 64'(3'b100));
        wait_stat(2);
        m_req[2] = 1'b0;

        // R8: locked burst keeps ownership over higher priority
        @(negedge clk);
        set_req(2, 1'b0, 1'b1, 16'h0040, 8'd2);
        wait_beat();
        set_req(0, 1'b0, 1'b0, 16'h0010, 8'd1);
        wait_stat(2);
        chk("R8 locked burst ok", 64'(stat(2)), 64'(ST_OK));
        set_req(2, 1'b0, 1'b0, 16'h0042, 8'd1);
        @(negedge clk);
        wait_beat();
        chk("R8 lock owner granted again", 64'(m_beat), 64'(3'b100));
        wait_stat(2);
        m_req[2] = 1'b0;
        @(negedge clk);
        wait_beat();
        chk("R7 priority after lock released", 64'(m_beat), 64'(3'b001));
        wait_stat(0);
        m_req[0] = 1'b0;

        // R11: debug traffic during a burst
        @(negedge clk);
        set_req(0, 1'b0, 1'b0, 16'h0010, 8'd4);
        @(negedge clk);
        chk("R4 first beat after arbitration", 64'(m_beat), 64'(3'b001));
        d_req = 1'b1; d_wr = 1'b0; d_addr = 16'h0045;
        #1;
        chk("R11 debug read data", 64'(d_rdata), 64'(mem[8'h45] ^ tag(2)));
        chk("R11 debug select", 64'(ds_sel), 64'(3'b100));
        chk("R11 burst select untouched", 64'(s_sel), 64'(3'b001));
        d_wr = 1'b1; d_addr = 16'h0046; d_wdata = 32'h0CAF_E046;
        #1;
        chk("R11 debug write enable", 64'({ds_wr, ds_sel}), 64'({1'b1, 3'b100}));
        @(negedge clk);
        d_wr = 1'b0; d_addr = 16'h0035;
        #1;
        chk("R11 debug miss error", 64'({d_err, ds_sel}), 64'({1'b1, 3'b000}));
        chk("R11 burst address undisturbed", 64'(s_addr), 64'(16'h0011));
        d_addr = 16'h0046;
        #1;
        chk("R11 debug write landed", 64'(d_rdata), 64'(32'h0CAF_E046 ^ tag(2)));
        d_req = 1'b0;
        wait_stat(0);
        chk("R11 burst completes ok", 64'(stat(0)), 64'(ST_OK));
        m_req[0] = 1'b0;
        @(negedge clk);
        chk("R2 idle after drop", 64'(m_status), 64'(0));

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule